// File: doc/BRIEF.md
# Sixteen-bit ALU with overflow register

This block is the execution stage of a small 16-bit processor. Each accepted request carries a 4-bit operation code, two 16-bit operand values already fetched by the surrounding pipeline, and a flag that says the destination operand is a literal and cannot be written. The block computes the result and decides whether it is written back. It updates its internal 16-bit overflow register O according to a rule specific to each operation, and reports how many processor cycles the operation costs.

Conditional operations produce no result. Instead they raise a flag telling the sequencer to skip the next instruction. Division and modulo by zero are defined and yield zero rather than trapping. All outputs are registered: a request presented with `valid_i` high is answered on the outputs one clock later. The O register is visible on `o_o`.

Top module: `ovf_alu`

## Requirements
- R1: Opcode 0x1 (SET) writes b as the result, leaves O unchanged and costs 1 cycle.
- R2: Opcode 0x2 (ADD) writes (a+b) mod 2^16, sets O to 1 when the unsigned sum exceeds 0xffff and to 0 otherwise, and costs 2 cycles.
- R3: Opcode 0x3 (SUB) writes (a-b) mod 2^16, sets O to 1 when b > a (unsigned) and to 0 otherwise, and costs 2 cycles.
- R4: Opcode 0x4 (MUL) writes the low 16 bits of the 32-bit product and sets O to its high 16 bits. Opcode 0x7 (SHL) does the same with a shifted left by b inside a 32-bit frame, where b >= 32 gives 0 for both. Both cost 2 cycles.
- R5: Opcode 0x8 (SHR) writes a >> b, sets O to bits 15:0 of ((a << 16) >> b) in a 32-bit frame, and costs 2 cycles.
- R6: Opcode 0x5 (DIV) writes the unsigned quotient a / b, sets O to ((a << 16) / b) & 0xffff, and costs 3 cycles. When b is 0, both the result and O become 0.
- R7: Opcode 0x6 (MOD) writes a % b, leaves O unchanged and costs 3 cycles. When b is 0, the result is 0.
- R8: Opcodes 0x9, 0xA and 0xB write a&b, a|b and a^b respectively, leave O unchanged and cost 1 cycle.
- R9: Opcodes 0xC, 0xD, 0xE and 0xF never write and leave O unchanged. They cost 2 cycles. They raise skip when, respectively, a != b, a == b, a <= b (unsigned), or (a & b) == 0.
- R10: With the literal-destination flag set, write enable stays low, but O updates exactly as it would for a writable destination.
- R11: Opcode 0x0 is inert: no write, no skip, a cost of 0, and O unchanged.
- R12: Outputs follow an accepted request by one clock. In a cycle after `valid_i` was low, write enable and skip are 0, the cost is 0 and O holds its value. After reset, O is 0 and all flags and the cost are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request present this cycle |
| op_i | input | 4 | Operation code |
| a_i | input | 16 | First operand (destination value) |
| b_i | input | 16 | Second operand |
| dst_lit_i | input | 1 | Destination is a literal; suppress the write |
| res_o | output | 16 | Result value |
| we_o | output | 1 | Result write enable |
| o_o | output | 16 | Overflow register O |
| skip_o | output | 1 | Skip the next instruction |
| cyc_o | output | 2 | Cycle cost of the operation |

## Verification
On every cycle, the assertions check several properties. No write follows a literal destination, and write and skip never appear together. O stays put after an idle cycle, and the idle response is silent. Division by zero clears both values, modulo by zero preserves O, and the logical operations cost one cycle. Whether each arithmetic result and O value is numerically right is shown only by the bench's scenarios. These compare random and directed operand pairs against an independent model: carry and borrow edges, full-range products, shift amounts at and past the word width, and zero divisors.

// File: rtl/ovf_alu_pkg.sv
package ovf_alu_pkg;
  typedef enum logic [3:0] {
    OP_NOP = 4'h0, OP_SET = 4'h1, OP_ADD = 4'h2, OP_SUB = 4'h3,
    OP_MUL = 4'h4, OP_DIV = 4'h5, OP_MOD = 4'h6, OP_SHL = 4'h7,
    OP_SHR = 4'h8, OP_AND = 4'h9, OP_BOR = 4'ha, OP_XOR = 4'hb,
    OP_IFE = 4'hc, OP_IFN = 4'hd, OP_IFG = 4'he, OP_IFB = 4'hf
  } alu_op_e;

  localparam int unsigned COST_LOGIC = 1;
  localparam int unsigned COST_ARITH = 2;
  localparam int unsigned COST_DIVIDE = 3;
  localparam int unsigned COST_COND = 2;
endpackage

// File: rtl/ovf_alu_arith.sv
module ovf_alu_arith #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] add_res_o,
  output logic [W-1:0] add_ovf_o,
  output logic [W-1:0] sub_res_o,
  output logic [W-1:0] sub_ovf_o,
  output logic [W-1:0] mul_res_o,
  output logic [W-1:0] mul_ovf_o,
  output logic [W-1:0] shl_res_o,
  output logic [W-1:0] shl_ovf_o,
  output logic [W-1:0] shr_res_o,
  output logic [W-1:0] shr_ovf_o
);
  localparam int unsigned DW = 2 * W;

  logic [W:0]    sum;
  logic [DW-1:0] prod;
  logic [DW-1:0] shl_full;
  logic [DW-1:0] shr_full;

  assign sum      = {1'b0, a_i} + {1'b0, b_i};
  assign prod     = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
  assign shl_full = {{W{1'b0}}, a_i} << b_i;
  // upper half is a>>b, lower half carries the bits shifted out
  assign shr_full = {a_i, {W{1'b0}}} >> b_i;

  assign add_res_o = sum[W-1:0];
  assign add_ovf_o = {{(W-1){1'b0}}, sum[W]};
  assign sub_res_o = a_i - b_i;
  assign sub_ovf_o = {{(W-1){1'b0}}, (b_i > a_i)};
  assign mul_res_o = prod[W-1:0];
  assign mul_ovf_o = prod[DW-1:W];
  assign shl_res_o = shl_full[W-1:0];
  assign shl_ovf_o = shl_full[DW-1:W];
  assign shr_res_o = shr_full[DW-1:W];
  assign shr_ovf_o = shr_full[W-1:0];
endmodule

// File: rtl/ovf_alu_divmod.sv
module ovf_alu_divmod #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] frac_o,
  output logic [W-1:0] rem_o
);
  localparam int unsigned DW = 2 * W;

  logic          b_zero;
  logic [DW-1:0] wide_q;

  assign b_zero = (b_i == '0);
  // one wide divide yields both the quotient (upper) and O (lower)
  assign wide_q = b_zero ? '0 : ({a_i, {W{1'b0}}} / {{W{1'b0}}, b_i});
  assign quo_o  = wide_q[DW-1:W];
  assign frac_o = wide_q[W-1:0];
  assign rem_o  = b_zero ? '0 : (a_i % b_i);
endmodule

// File: rtl/ovf_alu_cond.sv
module ovf_alu_cond
  import ovf_alu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         is_cond_o,
  output logic         skip_o
);
  logic eq, gt, any_bit;

  assign eq      = (a_i == b_i);
  assign gt      = (a_i > b_i);
  assign any_bit = |(a_i & b_i);

  always_comb begin
    is_cond_o = 1'b1;
    skip_o    = 1'b0;
    unique case (op_i)
      OP_IFE:  skip_o = !eq;
      OP_IFN:  skip_o = eq;
      OP_IFG:  skip_o = !gt;
      OP_IFB:  skip_o = !any_bit;
      default: is_cond_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ovf_alu_cost.sv
module ovf_alu_cost
  import ovf_alu_pkg::*;
#(
  parameter int unsigned CW = 2
) (
  input  alu_op_e       op_i,
  output logic [CW-1:0] cyc_o
);
  always_comb begin
    unique case (op_i)
      OP_NOP:                          cyc_o = '0;
      OP_SET, OP_AND, OP_BOR, OP_XOR:  cyc_o = CW'(COST_LOGIC);
      OP_DIV, OP_MOD:                  cyc_o = CW'(COST_DIVIDE);
      OP_IFE, OP_IFN, OP_IFG, OP_IFB:  cyc_o = CW'(COST_COND);
      default:                         cyc_o = CW'(COST_ARITH);
    endcase
  end
endmodule

// File: rtl/ovf_alu.sv
module ovf_alu
  import ovf_alu_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [3:0]    op_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic          dst_lit_i,
  output logic [W-1:0]  res_o,
  output logic          we_o,
  output logic [W-1:0]  o_o,
  output logic          skip_o,
  output logic [CW-1:0] cyc_o
);
  alu_op_e op;
  assign op = alu_op_e'(op_i);

  logic [W-1:0] add_r, add_v, sub_r, sub_v, mul_r, mul_v;
  logic [W-1:0] shl_r, shl_v, shr_r, shr_v;
  logic [W-1:0] quo, frac, rem;
  logic         is_cond, cond_skip;
  logic [CW-1:0] cost;

  ovf_alu_arith #(.W(W)) u_arith (
    .a_i(a_i), .b_i(b_i),
    .add_res_o(add_r), .add_ovf_o(add_v),
    .sub_res_o(sub_r), .sub_ovf_o(sub_v),
    .mul_res_o(mul_r), .mul_ovf_o(mul_v),
    .shl_res_o(shl_r), .shl_ovf_o(shl_v),
    .shr_res_o(shr_r), .shr_ovf_o(shr_v)
  );

  ovf_alu_divmod #(.W(W)) u_divmod (
    .a_i(a_i), .b_i(b_i), .quo_o(quo), .frac_o(frac), .rem_o(rem)
  );

  ovf_alu_cond #(.W(W)) u_cond (
    .op_i(op), .a_i(a_i), .b_i(b_i), .is_cond_o(is_cond), .skip_o(cond_skip)
  );

  ovf_alu_cost #(.CW(CW)) u_cost (.op_i(op), .cyc_o(cost));

  logic [W-1:0] res_d, o_d;
  logic         wr_d;

  always_comb begin
    res_d = '0;
    o_d   = o_o;
    wr_d  = 1'b1;
    unique case (op)
      OP_SET: res_d = b_i;
      OP_ADD: begin res_d = add_r; o_d = add_v; end
      OP_SUB: begin res_d = sub_r; o_d = sub_v; end
      OP_MUL: begin res_d = mul_r; o_d = mul_v; end
      OP_DIV: begin res_d = quo;   o_d = frac;  end
      OP_MOD: res_d = rem;
      OP_SHL: begin res_d = shl_r; o_d = shl_v; end
      OP_SHR: begin res_d = shr_r; o_d = shr_v; end
      OP_AND: res_d = a_i & b_i;
      OP_BOR: res_d = a_i | b_i;
      OP_XOR: res_d = a_i ^ b_i;
      default: wr_d = 1'b0;  // NOP and conditionals
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o  <= '0;
      we_o   <= 1'b0;
      o_o    <= '0;
      skip_o <= 1'b0;
      cyc_o  <= '0;
    end else begin
      we_o   <= valid_i && wr_d && !dst_lit_i;
      skip_o <= valid_i && is_cond && cond_skip;
      cyc_o  <= valid_i ? cost : '0;
      if (valid_i) begin
        res_o <= res_d;
        o_o   <= o_d;
      end
    end
  end

  a_r10_lit_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && dst_lit_i |=> !we_o);

  a_r9_skip_never_writes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(skip_o && we_o));

  a_r12_idle_holds_o: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(o_o) && !we_o && !skip_o && cyc_o == '0));

  a_r6_div_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op == OP_DIV && b_i == '0 |=> (o_o == '0 && res_o == '0));

  a_r7_mod_zero_keeps_o: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op == OP_MOD && b_i == '0 |=> (res_o == '0 && $stable(o_o)));

  a_r8_logic_cost: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op == OP_AND || op == OP_BOR || op == OP_XOR)
    |=> (cyc_o == CW'(1) && $stable(o_o)));
endmodule

// File: tb/ovf_alu_tb.sv
`timescale 1ns/1ps
module ovf_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  op = '0;
  logic [15:0] a = '0, b = '0;
  logic        lit = 1'b0;
  logic [15:0] res, o_val;
  logic        we, skip;
  logic [1:0]  cyc;

  int total = 0;
  int bad = 0;
  logic [15:0] exp_o = '0;

  always #2.5 clk = ~clk;

  ovf_alu u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .a_i(a), .b_i(b),
    .dst_lit_i(lit), .res_o(res), .we_o(we), .o_o(o_val), .skip_o(skip), .cyc_o(cyc)
  );

  task automatic check(string tag, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(logic [3:0] o);
    case (o)
      4'h0: return "R11";
      4'h1: return "R1";
      4'h2: return "R2";
      4'h3: return "R3";
      4'h4, 4'h7: return "R4";
      4'h8: return "R5";
      4'h5: return "R6";
      4'h6: return "R7";
      4'h9, 4'ha, 4'hb: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic model(input logic [3:0] o, input logic [15:0] x, input logic [15:0] y,
                       input logic [15:0] o_in, output logic [15:0] r, output bit wr,
                       output bit sk, output logic [15:0] o_out, output int cy);
    longint full;
    r = '0; wr = 1'b1; sk = 1'b0; o_out = o_in; cy = 2;
    case (o)
      4'h0: begin wr = 1'b0; cy = 0; end
      4'h1: begin r = y; cy = 1; end
      4'h2: begin full = longint'(x) + longint'(y); r = full[15:0]; o_out = (full > 65535) ? 16'd1 : 16'd0; end
      4'h3: begin r = x - y; o_out = (y > x) ? 16'd1 : 16'd0; end
      4'h4: begin full = longint'(x) * longint'(y); r = full[15:0]; o_out = full[31:16]; end
      4'h5: begin
        cy = 3;
        if (y == 0) begin r = 0; o_out = 0; end
        else begin r = x / y; full = (longint'(x) << 16) / longint'(y); o_out = full[15:0]; end
      end
      4'h6: begin cy = 3; r = (y == 0) ? 16'd0 : x % y; end
      4'h7: begin full = (y >= 32) ? 0 : (longint'(x) << y); r = full[15:0]; o_out = full[31:16]; end
      4'h8: begin
        full = (y >= 32) ? 0 : ((longint'(x) << 16) >> y);
        r = (y >= 16) ? 16'd0 : (x >> y); o_out = full[15:0];
      end
      4'h9: begin r = x & y; cy = 1; end
      4'ha: begin r = x | y; cy = 1; end
      4'hb: begin r = x ^ y; cy = 1; end
      4'hc: begin wr = 1'b0; sk = (x != y); end
      4'hd: begin wr = 1'b0; sk = (x == y); end
      4'he: begin wr = 1'b0; sk = !(x > y); end
      default: begin wr = 1'b0; sk = ((x & y) == 0); end
    endcase
  endtask

  task automatic run_op(logic [3:0] o, logic [15:0] x, logic [15:0] y, bit l);
    logic [15:0] er, eo; bit ew, es; int ec; string t;
    @(negedge clk);
    op = o; a = x; b = y; lit = l; valid = 1'b1;
    model(o, x, y, exp_o, er, ew, es, eo, ec);
    t = l ? "R10" : tag_of(o);
    @(negedge clk);
    valid = 1'b0;
    check(t, "we", we, ew && !l);
    if (ew && !l) check(t, "res", res, er);
    check(t, "skip", skip, es);
    check(t, "O", o_val, eo);
    check(t, "cyc", cyc, ec);
    exp_o = eo;
  endtask

  task automatic idle_check();
    @(negedge clk);
    check("R12", "idle we", we, 0);
    check("R12", "idle skip", skip, 0);
    check("R12", "idle cyc", cyc, 0);
    check("R12", "idle O", o_val, exp_o);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R12", "reset O", o_val, 0);
    check("R12", "reset we", we, 0);
    check("R12", "reset skip", skip, 0);
    check("R12", "reset cyc", cyc, 0);
    rst_n = 1'b1;

    run_op(4'h1, 16'h1111, 16'habcd, 0);   // R1
    run_op(4'h2, 16'hffff, 16'h0001, 0);   // R2 carry -> O=1
    idle_check();
    run_op(4'h2, 16'h1234, 16'h0001, 0);   // R2 no carry
    run_op(4'h3, 16'h0000, 16'h0001, 0);   // R3 borrow
    run_op(4'h3, 16'h0005, 16'h0003, 0);   // R3 no borrow
    run_op(4'h4, 16'hffff, 16'hffff, 0);   // R4 MUL
    run_op(4'h7, 16'h8000, 16'h0001, 0);   // R4 SHL
    run_op(4'h7, 16'h1234, 16'd40, 0);     // R4 SHL past frame
    run_op(4'h8, 16'h0001, 16'h0001, 0);   // R5
    run_op(4'h8, 16'hffff, 16'd20, 0);     // R5 shift beyond word
    run_op(4'h5, 16'h0001, 16'h0002, 0);   // R6 fraction
    run_op(4'h5, 16'h7777, 16'h0000, 0);   // R6 zero divisor
    run_op(4'h2, 16'hffff, 16'hffff, 0);   // set O=1
    run_op(4'h6, 16'h0007, 16'h0000, 0);   // R7 zero divisor, O kept
    run_op(4'h6, 16'h0017, 16'h0005, 0);   // R7
    run_op(4'h9, 16'hf0f0, 16'h3c3c, 0);   // R8
    run_op(4'ha, 16'hf0f0, 16'h3c3c, 0);
    run_op(4'hb, 16'hf0f0, 16'h3c3c, 0);
    run_op(4'hc, 16'h0042, 16'h0042, 0);   // R9 equal -> no skip
    run_op(4'hd, 16'h0042, 16'h0042, 0);
    run_op(4'he, 16'h0042, 16'h0042, 0);   // R9 a<=b -> skip
    run_op(4'hf, 16'h00f0, 16'h000f, 0);
    run_op(4'h2, 16'hffff, 16'h0002, 1);   // R10 literal, O still 1
    run_op(4'h3, 16'h0009, 16'h0002, 1);   // R10 literal, O to 0
    run_op(4'h0, 16'h1234, 16'h5678, 0);   // R11
    idle_check();

    for (int i = 0; i < 3000; i++) begin
      logic [15:0] rb;
      rb = 16'($urandom);
      if (($urandom % 4) == 0) rb = rb & 16'h001f;
      if (($urandom % 16) == 0) rb = 16'h0000;
      run_op(4'($urandom), 16'($urandom), rb, ($urandom % 8) == 0);
    end
    idle_check();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule